// File: doc/BRIEF.md
# Serial Register-Write Control Port

This block is the slave front end of a control port that accepts register writes over a three-wire serial link: an active-low select line, a bit clock and a data line. All three inputs are asynchronous to the system clock. They are brought into the clock domain by two-flop synchronisers, and the bit-clock rising edges are found in that domain.

A frame opens with a 7-bit device identifier and a direction flag. A pointer byte follows. Its top bit chooses whether the pointer steps after each write or stays fixed. Every data byte after that comes out as a single-cycle write strobe with a 7-bit register address and 8 bits of data, for a register file outside this block.

The select line also serves as an address strap when the port runs in its other serial mode. The block starts in that other mode after reset. It latches the serial mode for good on the first falling edge it sees on the select line, and decodes frames only once that has happened.

Top module: `spi_regwr_port`

## Requirements
- R1: After reset, `spi_mode_o` is 0 and `wr_stb_o` is 0.
- R2: `spi_mode_o` goes to 1 after the first falling edge on `sel_n_i` following reset. It then stays 1, whatever the serial inputs do, until the next reset. A rising edge on its own does not set it.
- R3: Bits are taken on rising edges of `sclk_i` only while `sel_n_i` is low and `spi_mode_o` is 1, most significant bit first. Clock edges at any other time produce no write.
- R4: The first byte of a frame must be 8'h20: identifier 7'b0010000 in bits 7:1 and write flag 0 in bit 0. Any other value, including the read flag (8'h21), makes the block drop the rest of the frame, with no strobes until `sel_n_i` goes high.
- R5: The second byte loads the pointer. Bit 7 is the step-enable flag and bits 6:0 are the register address. The first data byte is written to that address.
- R6: With the step-enable flag at 0, every data byte of the frame is written to the same address.
- R7: With the step-enable flag at 1, the address goes up by one after each data byte and wraps from 7'h7F to 7'h00.
- R8: Each completed data byte gives exactly one strobe, one clock cycle wide, carrying the address and the byte. Non-data bytes give none.
- R9: Raising `sel_n_i` at any point ends the frame and throws away a partial byte. The next frame starts again at the identifier byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n_i | input | 1 | Asynchronous select / address-strap line, active low |
| sclk_i | input | 1 | Asynchronous serial bit clock |
| sdi_i | input | 1 | Asynchronous serial data in |
| spi_mode_o | output | 1 | 1 once the serial mode is latched |
| wr_stb_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 7 | Register address for the strobe |
| wr_data_o | output | 8 | Data byte for the strobe |

## Verification
The assertions assume that the serial bit clock runs several system-clock cycles per phase. Under that assumption two strobes can never land on adjacent cycles. They also assume that the data line is stable at the synchronised rising edge. The bench holds each bit-clock phase for four system clocks and changes data only while the bit clock is low. The check that no write follows a raised select line allows for the synchroniser latency, because it looks at the pin three cycles in the past. The bench waits that long before it samples any result.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;

    localparam int REG_AW = 7;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDENT = 2'd0,
        ST_PTR   = 2'd1,
        ST_DATA  = 2'd2,
        ST_DROP  = 2'd3
    } frame_st_t;

    typedef struct packed {
        logic [REG_AW-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    // Identifier in bits 7:1, direction in bit 0 (0 = write)
    function automatic logic ident_ok(input logic [7:0] b, input logic [6:0] id);
        return (b[7:1] == id) && !b[0];
    endfunction

    // Pointer step with natural wrap at the top of the address space
    function automatic logic [REG_AW-1:0] ptr_step(input logic [REG_AW-1:0] p);
        return p + 1'b1;
    endfunction

endpackage

// File: rtl/ctlp_sync.sv
module ctlp_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    generate
        for (genvar g = 0; g < W; g++) begin : g_bit
            logic s1, s2, s3;
            always_ff @(posedge clk) begin
                if (rst) begin
                    s1 <= 1'b0;
                    s2 <= 1'b0;
                    s3 <= 1'b0;
                end else begin
                    s1 <= pin_i[g];
                    s2 <= s1;
                    s3 <= s2;
                end
            end
            assign lvl_o[g]  = s2;
            assign rise_o[g] = s2 & ~s3;
            assign fall_o[g] = ~s2 & s3;
        end
    endgenerate
endmodule

// File: rtl/ctlp_mode_latch.sv
module ctlp_mode_latch (
    input  logic clk,
    input  logic rst,
    input  logic sel_fall_i,
    output logic mode_o
);
    always_ff @(posedge clk) begin
        if (rst)
            mode_o <= 1'b0;
        else if (sel_fall_i)
            mode_o <= 1'b1;
    end
endmodule

// File: rtl/ctlp_frame.sv
module ctlp_frame
    import ctlp_pkg::*;
#(
    parameter logic [6:0] CHIP_ID = 7'b0010000
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    enable_i,
    input  logic    sel_lvl_i,
    input  logic    sclk_rise_i,
    input  logic    sdi_lvl_i,
    output logic    stb_o,
    output wr_req_t req_o
);
    localparam int CNT_W = $clog2(DATA_W);

    frame_st_t         st;
    logic [CNT_W-1:0]  bitcnt;
    logic [DATA_W-2:0] shreg;
    logic [REG_AW-1:0] ptr;
    logic              step_en;
    logic [DATA_W-1:0] byte_w;

    assign byte_w = {shreg, sdi_lvl_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDENT;
            bitcnt  <= '0;
            shreg   <= '0;
            ptr     <= '0;
            step_en <= 1'b0;
            stb_o   <= 1'b0;
            req_o   <= '0;
        end else begin
            stb_o <= 1'b0;
            if (sel_lvl_i) begin
                st     <= ST_IDENT;
                bitcnt <= '0;
            end else if (sclk_rise_i && enable_i) begin
                shreg  <= byte_w[DATA_W-2:0];
                bitcnt <= bitcnt + 1'b1;
                if (bitcnt == CNT_W'(DATA_W-1)) begin
                    case (st)
                        ST_IDENT: st <= ident_ok(byte_w, CHIP_ID) ? ST_PTR : ST_DROP;
                        ST_PTR: begin
                            step_en <= byte_w[7];
                            ptr     <= byte_w[REG_AW-1:0];
                            st      <= ST_DATA;
                        end
                        ST_DATA: begin
                            stb_o      <= 1'b1;
                            req_o.addr <= ptr;
                            req_o.data <= byte_w;
                            if (step_en)
                                ptr <= ptr_step(ptr);
                        end
                        default: st <= ST_DROP;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/spi_regwr_port.sv
module spi_regwr_port
    import ctlp_pkg::*;
#(
    parameter logic [6:0] CHIP_ID = 7'b0010000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sel_n_i,
    input  logic        sclk_i,
    input  logic        sdi_i,
    output logic        spi_mode_o,
    output logic        wr_stb_o,
    output logic [6:0]  wr_addr_o,
    output logic [7:0]  wr_data_o
);
    logic [2:0] lvl, rise, fall;
    wr_req_t    req;

    ctlp_sync #(.W(3)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  ({sdi_i, sclk_i, sel_n_i}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    ctlp_mode_latch u_mode (
        .clk        (clk),
        .rst        (rst),
        .sel_fall_i (fall[0]),
        .mode_o     (spi_mode_o)
    );

    ctlp_frame #(.CHIP_ID(CHIP_ID)) u_frame (
        .clk         (clk),
        .rst         (rst),
        .enable_i    (spi_mode_o),
        .sel_lvl_i   (lvl[0]),
        .sclk_rise_i (rise[1]),
        .sdi_lvl_i   (lvl[2]),
        .stb_o       (wr_stb_o),
        .req_o       (req)
    );

    assign wr_addr_o = req.addr;
    assign wr_data_o = req.data;

    logic unused_ok;
    assign unused_ok = &{1'b0, rise[0], rise[2], fall[2:1]};
endmodule

// File: rtl/spi_regwr_port_chk.sv
module spi_regwr_port_chk (
    input logic clk,
    input logic rst,
    input logic sel_n_i,
    input logic spi_mode_o,
    input logic wr_stb_o
);
    // R1: reset clears mode and strobe
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!spi_mode_o && !wr_stb_o));

    // R2: once latched, mode holds until reset
    a_r2_mode_sticky: assert property (@(posedge clk) disable iff (rst)
        spi_mode_o |=> spi_mode_o);

    // R3: no write before the mode is latched
    a_r3_no_write_without_mode: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |-> spi_mode_o);

    // R8: strobe is one cycle wide
    a_r8_single_cycle_stb: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |=> !wr_stb_o);

    // R9: select held high (allowing synchroniser latency) means no write
    a_r9_no_write_when_deselected: assert property (@(posedge clk) disable iff (rst)
        ($past(sel_n_i, 3) && $past(sel_n_i, 2)) |-> !wr_stb_o);
endmodule

bind spi_regwr_port spi_regwr_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sel_n_i    (sel_n_i),
    .spi_mode_o (spi_mode_o),
    .wr_stb_o   (wr_stb_o)
);

// File: tb/tb_spi_regwr_port.sv
`timescale 1ns/1ps
module tb_spi_regwr_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic       spi_mode;
    logic       wr_stb;
    logic [6:0] wr_addr;
    logic [7:0] wr_data;

    int total = 0;
    int bad = 0;
    int ncap = 0;
    int wide_err = 0;
    logic [6:0] cap_a [0:31];
    logic [7:0] cap_d [0:31];
    logic prev_stb = 1'b0;

    always #5 clk = ~clk;

    spi_regwr_port dut (
        .clk(clk), .rst(rst), .sel_n_i(sel_n), .sclk_i(sclk), .sdi_i(sdi),
        .spi_mode_o(spi_mode), .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
    );

    always @(negedge clk) begin
        if (wr_stb) begin
            if (ncap < 32) begin
                cap_a[ncap] = wr_addr;
                cap_d[ncap] = wr_data;
            end
            ncap = ncap + 1;
        end
        if (wr_stb && prev_stb) wide_err = wide_err + 1;
        prev_stb = wr_stb;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdi = b;
        wait_clk(4);
        sclk = 1'b1;
        wait_clk(4);
        sclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic sel_low;
        sel_n = 1'b0;
        wait_clk(6);
    endtask

    task automatic sel_high;
        wait_clk(4);
        sel_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic do_reset(input logic sel_level);
        sel_n = sel_level;
        rst = 1'b1;
        wait_clk(4);
        @(negedge clk);
        rst = 1'b0;
        wait_clk(6);
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        chk("R1 mode after reset", int'(spi_mode), 0);
        chk("R1 strobe after reset", int'(wr_stb), 0);
    endtask

    task automatic t_no_mode_no_decode;
        // Select pin held low through reset: no falling edge is ever seen
        do_reset(1'b0);
        ncap = 0;
        send_byte(8'h20); send_byte(8'h05); send_byte(8'hA5);
        wait_clk(8);
        @(negedge clk);
        chk("R3 no writes before mode latched", ncap, 0);
        chk("R2 mode stays 0 without falling edge", int'(spi_mode), 0);
        sel_n = 1'b1;
        wait_clk(8);
        @(negedge clk);
        chk("R2 rising edge alone does not latch", int'(spi_mode), 0);
    endtask

    task automatic t_basic_write;
        ncap = 0;
        sel_low();
        @(negedge clk);
        chk("R2 mode latched by falling edge", int'(spi_mode), 1);
        send_byte(8'h20); send_byte(8'h05); send_byte(8'hA5);
        sel_high();
        chk("R8 one strobe for one data byte", ncap, 1);
        chk("R5 address from pointer", int'(cap_a[0]), 'h05);
        chk("R5 data byte", int'(cap_d[0]), 'hA5);
    endtask

    task automatic t_fixed_ptr;
        ncap = 0;
        sel_low();
        send_byte(8'h20); send_byte(8'h12);
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
        sel_high();
        chk("R6 three strobes", ncap, 3);
        chk("R6 addr 0", int'(cap_a[0]), 'h12);
        chk("R6 addr 1", int'(cap_a[1]), 'h12);
        chk("R6 addr 2", int'(cap_a[2]), 'h12);
        chk("R8 data 2", int'(cap_d[2]), 'h33);
    endtask

    task automatic t_step_wrap;
        ncap = 0;
        sel_low();
        send_byte(8'h20); send_byte(8'hFE);
        send_byte(8'h01); send_byte(8'h02); send_byte(8'h03); send_byte(8'h04);
        sel_high();
        chk("R7 four strobes", ncap, 4);
        chk("R7 addr 0", int'(cap_a[0]), 'h7E);
        chk("R7 addr 1", int'(cap_a[1]), 'h7F);
        chk("R7 wrap to 0", int'(cap_a[2]), 'h00);
        chk("R7 addr 3", int'(cap_a[3]), 'h01);
        chk("R7 data 3", int'(cap_d[3]), 'h04);
    endtask

    task automatic t_bad_ident;
        ncap = 0;
        sel_low();
        send_byte(8'h22); send_byte(8'h05); send_byte(8'h77);
        sel_high();
        chk("R4 wrong identifier ignored", ncap, 0);
        ncap = 0;
        sel_low();
        send_byte(8'h21); send_byte(8'h05); send_byte(8'h77); send_byte(8'h78);
        sel_high();
        chk("R4 read flag ignored", ncap, 0);
        ncap = 0;
        sel_low();
        send_byte(8'h20); send_byte(8'h06); send_byte(8'h99);
        sel_high();
        chk("R4 valid frame after rejected ones", ncap, 1);
        chk("R4 addr after rejected ones", int'(cap_a[0]), 'h06);
    endtask

    task automatic t_abort;
        ncap = 0;
        sel_low();
        send_byte(8'h20);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        sel_high();
        chk("R9 partial pointer gives no write", ncap, 0);
        sel_low();
        send_byte(8'h20); send_byte(8'h31); send_byte(8'h5A);
        sel_high();
        chk("R9 fresh frame after abort count", ncap, 1);
        chk("R9 fresh frame addr", int'(cap_a[0]), 'h31);
        chk("R9 fresh frame data", int'(cap_d[0]), 'h5A);
        ncap = 0;
        sel_low();
        send_byte(8'h20); send_byte(8'h40); send_byte(8'hC3);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        sel_high();
        chk("R9 partial data byte discarded", ncap, 1);
        chk("R9 completed byte kept", int'(cap_d[0]), 'hC3);
    endtask

    task automatic t_clock_while_deselected;
        ncap = 0;
        send_byte(8'h20); send_byte(8'h05); send_byte(8'h66);
        wait_clk(8);
        @(negedge clk);
        chk("R3 clock ignored while deselected", ncap, 0);
        chk("R2 mode still latched", int'(spi_mode), 1);
    endtask

    task automatic t_reset_clears_mode;
        do_reset(1'b1);
        @(negedge clk);
        chk("R1 reset clears latched mode", int'(spi_mode), 0);
    endtask

    initial begin
        do_reset(1'b1);
        t_reset_state();
        t_no_mode_no_decode();
        t_basic_write();
        t_fixed_ptr();
        t_step_wrap();
        t_bad_ident();
        t_abort();
        t_clock_while_deselected();
        chk("R8 strobe never wider than one cycle", wide_err, 0);
        t_reset_clears_mode();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule